// File: doc/BRIEF.md
# Clocked Serial Memory Streamer

This block reads a small byte memory out, one bit at a time, under an external slow clock. The block takes no commands. A mode controller enables it. The controller keeps the enable high only while the serial clock line of the bidirectional bus rests high. Each rising edge of the slow clock reaches the block as a one-cycle strobe, already synchronised to the system clock. Each strobe moves the output forward by one bit.

After reset, or after the enable has been low, the block ignores a run of strobes that it uses to synchronise. During that run the data output stays released. The strobe after that run drives the most significant bit of the byte at the current address. A byte takes nine strobes: eight data bits, most significant first, then one slot that carries no data and in which the output is released. The address then advances by one. From the top location it wraps to zero. The memory sits outside the block, behind a read port with one cycle of latency.

Top module: `vclk_stream_tx`

## Requirements
- R1: After reset, or after a period with the enable low, the first SYNC_PULSES (9) strobes taken with the enable high leave `sda_oe` at 0.
- R2: After reset, the strobe that follows the synchronising run sets `sda_oe` to 1 and drives `sda_out` with bit 7 of the byte at address 0.
- R3: Each byte takes DATA_W+1 (9) strobes. The first eight drive data bits 7 down to 0 with `sda_oe`=1. The ninth strobe releases the output: `sda_oe`=0 and `sda_out`=1.
- R4: `rd_addr` holds the address of the byte being sent. It goes up by one on the ninth strobe of each byte.
- R5: The address after DEPTH-1 (127) is 0.
- R6: While the enable is low, `sda_oe` is 0 from the next clock edge on and strobes have no effect: `rd_addr` does not change and no bit is driven.
- R7: Dropping the enable in the middle of a byte keeps the address. After a new synchronising run, that byte starts again from bit 7.
- R8: The outputs change only on a clock edge that samples a strobe, or on an edge where the enable is low. Strobes must come at least 3 clock cycles apart.
- R9: Synchronous active-high reset sets `sda_oe` to 0, `sda_out` to 1 and `rd_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Streaming enable from the mode controller |
| vclk_rise | input | 1 | One-cycle strobe marking a rising edge of the slow clock |
| rd_addr | output | ADDR_W (7) | Read address to the memory |
| rd_data | input | DATA_W (8) | Read data, valid one cycle after `rd_addr` |
| sda_out | output | 1 | Serial data bit |
| sda_oe | output | 1 | Output enable for the serial data pin |

## Verification
The bench targets the tenth strobe after reset. A design with an off-by-one preamble would drive one strobe early or late, and the first bit would not be bit 7 of address 0. It steps through the wrap from 127 to 0. A wrong wrap would run past the top or skip location 0. It drops the enable in the middle of a byte, pulses the strobe while the enable is low, and then looks at the retained address and the restarted byte. A design that kept the bit counter would resume in the middle of a byte. A design that cleared the address would start again from 0. It also checks that nothing moves between strobes and that the output is released in the ninth slot.

// File: rtl/tos_pkg.sv
package tos_pkg;
  localparam int TOS_DEPTH_DEF  = 128;
  localparam int TOS_DATA_W_DEF = 8;
  localparam int TOS_SYNC_DEF   = 9;
endpackage

// File: rtl/tos_preamble.sv
module tos_preamble #(
  parameter int SYNC_PULSES = 9,
  localparam int CW = $clog2(SYNC_PULSES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic step,
  output logic synced
);
  logic [CW-1:0] cnt_q;

  assign synced = (cnt_q == CW'(SYNC_PULSES));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (step && !synced) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tos_framer.sv
module tos_framer #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int SLOT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              step,
  output logic [SLOT_W-1:0] slot,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DATA_W);
  localparam logic [ADDR_W-1:0] TOP_ADDR  = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      slot <= '0;
    end else if (step) begin
      slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (en && step && slot == LAST_SLOT) begin
      addr <= (addr == TOP_ADDR) ? '0 : addr + 1'b1;
    end
  end
endmodule

// File: rtl/tos_shifter.sv
module tos_shifter #(
  parameter int DATA_W = 8,
  localparam int SLOT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              step,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_out,
  output logic              sda_oe
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sda_out <= 1'b1;
      sda_oe  <= 1'b0;
      sh_q    <= '0;
    end else if (step) begin
      if (slot == '0) begin
        sda_out <= rd_data[DATA_W-1];
        sh_q    <= rd_data << 1;
        sda_oe  <= 1'b1;
      end else if (slot < SLOT_W'(DATA_W)) begin
        sda_out <= sh_q[DATA_W-1];
        sh_q    <= sh_q << 1;
        sda_oe  <= 1'b1;
      end else begin
        sda_out <= 1'b1;
        sda_oe  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vclk_stream_tx.sv
module vclk_stream_tx #(
  parameter int DEPTH       = tos_pkg::TOS_DEPTH_DEF,
  parameter int DATA_W      = tos_pkg::TOS_DATA_W_DEF,
  parameter int SYNC_PULSES = tos_pkg::TOS_SYNC_DEF,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              vclk_rise,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_out,
  output logic              sda_oe
);
  localparam int SLOT_W = $clog2(DATA_W + 1);

  logic              synced;
  logic              bit_step;
  logic [SLOT_W-1:0] slot;

  // strobes advance the frame only once the preamble is complete
  assign bit_step = vclk_rise && synced;

  tos_preamble #(.SYNC_PULSES(SYNC_PULSES)) u_pre (
    .clk(clk), .rst(rst), .en(en), .step(vclk_rise), .synced(synced)
  );

  tos_framer #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_frm (
    .clk(clk), .rst(rst), .en(en), .step(bit_step), .slot(slot), .addr(rd_addr)
  );

  tos_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk(clk), .rst(rst), .en(en), .step(bit_step), .slot(slot),
    .rd_data(rd_data), .sda_out(sda_out), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/tos_checker.sv
module tos_checker #(
  parameter int DEPTH = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              vclk_rise,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              sda_out,
  input logic              sda_oe
);
  assert_release_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sda_oe);

  assert_hold_between_strobes_R8: assert property (@(posedge clk) disable iff (rst)
    (en && !vclk_rise) |=> ($stable(sda_oe) && $stable(sda_out)));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (en && !vclk_rise) |=> $stable(rd_addr));

  assert_addr_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_addr != $past(rd_addr)) |->
      (rd_addr == (($past(rd_addr) == ADDR_W'(DEPTH - 1)) ? '0 : $past(rd_addr) + 1'b1)));

  assert_addr_fixed_in_byte_R4: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> $stable(rd_addr));

  assert_drive_needs_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(vclk_rise));
endmodule

bind vclk_stream_tx tos_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/vclk_stream_tx_test.sv
module vclk_stream_tx_test;
  localparam int DEPTH = 128;
  localparam int DW    = 8;
  localparam int SYNC  = 9;

  logic       clk = 0;
  logic       rst = 1;
  logic       en  = 0;
  logic       vclk_rise = 0;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic       sda_out, sda_oe;

  logic [7:0] mem [DEPTH];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int m_cnt, m_slot, m_addr;
  bit first_after_reset;

  always #5 clk = ~clk;

  always_ff @(posedge clk) rd_data <= mem[rd_addr];

  vclk_stream_tx uut (
    .clk(clk), .rst(rst), .en(en), .vclk_rise(vclk_rise),
    .rd_addr(rd_addr), .rd_data(rd_data), .sda_out(sda_out), .sda_oe(sda_oe)
  );

  function automatic logic exp_bit(input int a, input int idx);
    return mem[a][DW-1-idx];
  endfunction

  function automatic int next_addr(input int a);
    return (a == DEPTH - 1) ? 0 : a + 1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one strobe; model updated from the requirements, outputs checked after the edge
  task automatic pulse(input int gap);
    logic oe_s, d_s;
    vclk_rise = 1;
    @(negedge clk);
    vclk_rise = 0;
    if (!en) begin
      check("R6 oe", sda_oe, 0);
      check("R6 addr", rd_addr, m_addr);
    end else if (m_cnt < SYNC) begin
      m_cnt++;
      check("R1 oe", sda_oe, 0);
    end else begin
      if (m_slot < DW) begin
        check(first_after_reset ? "R2 oe" : "R3 oe", sda_oe, 1);
        check(first_after_reset ? "R2 bit" : "R3 bit", sda_out, exp_bit(m_addr, m_slot));
        check("R4 addr", rd_addr, m_addr);
        first_after_reset = 0;
      end else begin
        check("R3 release oe", sda_oe, 0);
        check("R3 release level", sda_out, 1);
        m_addr = next_addr(m_addr);
        check(m_addr == 0 ? "R5 wrap" : "R4 incr", rd_addr, m_addr);
      end
      m_slot = (m_slot == DW) ? 0 : m_slot + 1;
    end
    oe_s = sda_oe;
    d_s  = sda_out;
    repeat (gap - 1) @(negedge clk);
    check("R8 oe stable", sda_oe, oe_s);
    check("R8 data stable", sda_out, d_s);
  endtask

  task automatic drop_en(input int n_low);
    en = 0;
    @(negedge clk);
    check("R6 released", sda_oe, 0);
    m_cnt  = 0;
    m_slot = 0;
    for (int i = 0; i < n_low; i++) pulse(3);
    en = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int saved;
    void'($urandom(32'd1729));
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'($urandom);
    mem[0] = 8'hA5;
    mem[DEPTH-1] = 8'h3C;
    repeat (3) @(negedge clk);
    check("R9 oe", sda_oe, 0);
    check("R9 data", sda_out, 1);
    check("R9 addr", rd_addr, 0);
    rst = 0;
    en  = 1;
    m_cnt = 0; m_slot = 0; m_addr = 0;
    first_after_reset = 1;
    @(negedge clk);
    // preamble, first byte and a full lap past the wrap point
    for (int i = 0; i < SYNC + (DEPTH + 3) * (DW + 1); i++) pulse(3 + int'($urandom_range(0, 3)));
    // mid-byte enable drops: address kept, byte restarts after a new preamble
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < int'($urandom_range(1, 30)); i++) pulse(3 + int'($urandom_range(0, 3)));
      saved = m_addr;
      drop_en(int'($urandom_range(0, 3)));
      check("R7 addr kept", rd_addr, saved);
      for (int i = 0; i <= SYNC; i++) pulse(3);
      check("R7 restart bit7", sda_out, exp_bit(saved, 0));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule